// File: doc/BRIEF.md
# I2C Serial Clock Divider

This block turns the system clock into the serial clock timing of an I2C master. Two programmable prescalers run in cascade: a coarse stage whose factor is 1 to 4 and a fine stage whose factor is 1 to 64. Their combined output is a tick. Each bit on the bus lasts 22 ticks, so the serial clock frequency is the input frequency divided by 22·(A+1)·(B+1). With both fields at zero the block runs at its fastest rate, one twenty-second of the input clock. Usual settings give 100 kHz or 400 kHz, and 400 kHz is the highest rate in use. Software chooses the field values.

Inside each bit the serial clock is driven low for ticks 0 to 10 and released high for ticks 11 to 21. Single-cycle strobes tell the bus sequencer when to act. One marks the start of a bit. One marks the point where SDA may change, in the low half. One marks the rising SCL edge. One marks the point where SDA is sampled, in the high half, which is also where START and STOP conditions are placed. The divider fields are captured only while the block is disabled, so a bit in progress never changes length. A target that holds the clock low through the stretch input freezes the tick count while the divider is in the low half of the bit.

Top module: `i2c_scl_divider`

## Requirements
- R1: With fields A (`div_a_i`, 2 bits, value 0..3) and B (`div_b_i`, 6 bits, value 0..63), each tick lasts (A+1)·(B+1) clock cycles and each bit lasts 22·(A+1)·(B+1) cycles, counted between successive `bit_start_o` pulses when no stretch occurs.
- R2: While running, `scl_o` is 0 during ticks 0..10 of a bit and 1 during ticks 11..21.
- R3: `sda_change_o` is a one-cycle pulse in the first clock cycle of tick 5.
- R4: `sample_o` is a one-cycle pulse in the first clock cycle of tick 16, while `scl_o` is 1.
- R5: `bit_start_o` pulses in the first cycle of tick 0, and `scl_rise_o` pulses in the first cycle of tick 11, which is the same cycle in which `scl_o` rises. The first bit after `en_i` rises starts in the next clock cycle.
- R6: While `en_i` is 0, `scl_o` is 1 from the next cycle on and no strobe fires. The fields are captured on every clock edge while `en_i` is 0, and changes to them while `en_i` is 1 have no effect.
- R7: While `stretch_i` is 1 during ticks 0..10, counting stops, `scl_o` stays 0, and the bit grows by one cycle for each stretched cycle. `stretch_i` has no effect during ticks 11..21.
- R8: During and directly after reset (`rst_ni` = 0), `scl_o` is 1 and all strobes are 0.
- R9: At most one of the four strobes is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low means idle and captures the fields |
| div_a_i | input | 2 | Coarse prescaler field A, factor A+1 |
| div_b_i | input | 6 | Fine prescaler field B, factor B+1 |
| stretch_i | input | 1 | Clock held low by a target; freezes counting in the low half |
| scl_o | output | 1 | Serial clock level to drive (0 = pull low, 1 = release) |
| bit_start_o | output | 1 | Strobe at tick 0 |
| sda_change_o | output | 1 | Strobe at tick 5 |
| scl_rise_o | output | 1 | Strobe at tick 11 |
| sample_o | output | 1 | Strobe at tick 16 |

## Verification
The properties assume that `stretch_i` rises only when a target really holds the line low. They also assume the fields carry the wanted value in the last idle cycle before `en_i` rises, since that is the value captured. The stimulus sets the fields only while idle, except in the one scenario that changes them during a run to show they are ignored. It raises stretch only at chosen tick positions, in both the low and the high half of a bit, and it leaves `en_i` low for at least one cycle between runs, so each run starts from tick 0.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    localparam int unsigned BIT_TICKS   = 22;
    localparam int unsigned HIGH_FROM   = 11;
    localparam int unsigned DATA_TICK   = 5;
    localparam int unsigned SAMPLE_TICK = 16;
    localparam int unsigned PH_W        = $clog2(BIT_TICKS);

    typedef logic [PH_W-1:0] phase_t;

    localparam phase_t PH_FIRST  = phase_t'(0);
    localparam phase_t PH_LAST   = phase_t'(BIT_TICKS - 1);
    localparam phase_t PH_RISE   = phase_t'(HIGH_FROM);
    localparam phase_t PH_DATA   = phase_t'(DATA_TICK);
    localparam phase_t PH_SAMPLE = phase_t'(SAMPLE_TICK);

    typedef struct packed {
        phase_t ph;
        logic   bit_start;
        logic   data_chg;
        logic   rise;
        logic   sample;
    } phase_state_t;

endpackage

// File: rtl/scl_div_stage.sv
module scl_div_stage #(
    parameter int unsigned W = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         step_i,
    input  logic [W-1:0] limit_i,
    output logic         wrap_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } stage_t;

    stage_t s_d, s_q;
    logic   wrap;

    always_comb begin
        s_d  = s_q;
        wrap = step_i && (s_q.cnt == limit_i);
        if (clr_i) begin
            s_d.cnt = '0;
        end else if (step_i) begin
            s_d.cnt = wrap ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wrap_o = wrap;

endmodule

// File: rtl/scl_div_phase.sv
module scl_div_phase
    import scl_div_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic start_i,
    input  logic tick_i,
    output logic low_o,
    output logic bit_start_o,
    output logic data_chg_o,
    output logic rise_o,
    output logic sample_o
);

    phase_state_t p_d, p_q;
    phase_t       ph_next;

    always_comb begin
        p_d           = p_q;
        p_d.bit_start = 1'b0;
        p_d.data_chg  = 1'b0;
        p_d.rise      = 1'b0;
        p_d.sample    = 1'b0;
        ph_next       = (p_q.ph == PH_LAST) ? PH_FIRST : p_q.ph + 1'b1;
        if (clr_i) begin
            p_d.ph        = PH_FIRST;
            p_d.bit_start = start_i;
        end else if (tick_i) begin
            p_d.ph        = ph_next;
            p_d.bit_start = (ph_next == PH_FIRST);
            p_d.data_chg  = (ph_next == PH_DATA);
            p_d.rise      = (ph_next == PH_RISE);
            p_d.sample    = (ph_next == PH_SAMPLE);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign low_o       = (p_q.ph < PH_RISE);
    assign bit_start_o = p_q.bit_start;
    assign data_chg_o  = p_q.data_chg;
    assign rise_o      = p_q.rise;
    assign sample_o    = p_q.sample;

endmodule

// File: rtl/i2c_scl_divider.sv
module i2c_scl_divider #(
    parameter int unsigned DIVA_W = 2,
    parameter int unsigned DIVB_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [DIVA_W-1:0] div_a_i,
    input  logic [DIVB_W-1:0] div_b_i,
    input  logic              stretch_i,
    output logic              scl_o,
    output logic              bit_start_o,
    output logic              sda_change_o,
    output logic              scl_rise_o,
    output logic              sample_o
);

    typedef struct packed {
        logic              run;
        logic [DIVA_W-1:0] cfg_a;
        logic [DIVB_W-1:0] cfg_b;
    } ctl_t;

    ctl_t c_d, c_q;
    logic low_half;
    logic freeze;
    logic step_a;
    logic wrap_a;
    logic tick;
    logic idle;

    // Fields are captured only while idle, so a running bit keeps its length.
    always_comb begin
        c_d     = c_q;
        c_d.run = en_i;
        if (!en_i) begin
            c_d.cfg_a = div_a_i;
            c_d.cfg_b = div_b_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign idle   = !c_q.run;
    assign freeze = stretch_i && low_half;
    assign step_a = c_q.run && en_i && !freeze;

    scl_div_stage #(.W(DIVA_W)) u_stage_a (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (idle),
        .step_i  (step_a),
        .limit_i (c_q.cfg_a),
        .wrap_o  (wrap_a)
    );

    scl_div_stage #(.W(DIVB_W)) u_stage_b (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (idle),
        .step_i  (wrap_a),
        .limit_i (c_q.cfg_b),
        .wrap_o  (tick)
    );

    scl_div_phase u_phase (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clr_i       (idle),
        .start_i     (en_i),
        .tick_i      (tick),
        .low_o       (low_half),
        .bit_start_o (bit_start_o),
        .data_chg_o  (sda_change_o),
        .rise_o      (scl_rise_o),
        .sample_o    (sample_o)
    );

    assign scl_o = !(c_q.run && low_half);

endmodule

// File: rtl/scl_div_chk.sv
module scl_div_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic en_i,
    input logic stretch_i,
    input logic scl_o,
    input logic bit_start_o,
    input logic sda_change_o,
    input logic scl_rise_o,
    input logic sample_o
);

    AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({bit_start_o, sda_change_o, scl_rise_o, sample_o})); // R9

    AST_SAMPLE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |=> !sample_o); // R4

    AST_SAMPLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |-> scl_o); // R4

    AST_DATA_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sda_change_o |-> !scl_o); // R3

    AST_RISE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scl_rise_o |-> $rose(scl_o)); // R5

    AST_FIRST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(en_i) |=> bit_start_o); // R5

    AST_IDLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (scl_o && !bit_start_o && !sample_o)); // R6

    AST_STRETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && stretch_i && !scl_o) |=> (!scl_o && !scl_rise_o)); // R7

endmodule

bind i2c_scl_divider scl_div_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .stretch_i    (stretch_i),
    .scl_o        (scl_o),
    .bit_start_o  (bit_start_o),
    .sda_change_o (sda_change_o),
    .scl_rise_o   (scl_rise_o),
    .sample_o     (sample_o)
);

// File: tb/i2c_scl_divider_tb_top.sv
module i2c_scl_divider_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       stretch = 1'b0;
    logic [1:0] da = 2'd0;
    logic [5:0] db = 6'd0;
    logic       scl, bs, dc, rs, sm;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference state
    bit m_run = 0;
    int m_k = 0, m_ph = 0, m_a = 0, m_b = 0;
    bit m_bs = 0, m_dc = 0, m_rs = 0, m_sm = 0;

    always #2 clk = ~clk;

    i2c_scl_divider dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .en_i         (en),
        .div_a_i      (da),
        .div_b_i      (db),
        .stretch_i    (stretch),
        .scl_o        (scl),
        .bit_start_o  (bs),
        .sda_change_o (dc),
        .scl_rise_o   (rs),
        .sample_o     (sm)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_k = 0; m_ph = 0; m_a = 0; m_b = 0;
            m_bs = 0; m_dc = 0; m_rs = 0; m_sm = 0;
        end else if (!en) begin
            m_run = 0; m_k = 0; m_ph = 0; m_a = da; m_b = db;
            m_bs = 0; m_dc = 0; m_rs = 0; m_sm = 0;
        end else if (!m_run) begin
            m_run = 1; m_k = 0; m_ph = 0;
            m_bs = 1; m_dc = 0; m_rs = 0; m_sm = 0;
        end else begin
            m_bs = 0; m_dc = 0; m_rs = 0; m_sm = 0;
            if (!(stretch && m_ph < 11)) begin
                if (m_k == (m_a + 1) * (m_b + 1) - 1) begin
                    m_k = 0;
                    m_ph = (m_ph + 1) % 22;
                    m_bs = (m_ph == 0);
                    m_dc = (m_ph == 5);
                    m_rs = (m_ph == 11);
                    m_sm = (m_ph == 16);
                end else begin
                    m_k++;
                end
            end
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(scl == !(m_run && m_ph < 11), "R2 scl level", int'(scl), int'(!(m_run && m_ph < 11)));
            check(bs == m_bs, "R5 bit_start", int'(bs), int'(m_bs));
            check(dc == m_dc, "R3 sda_change", int'(dc), int'(m_dc));
            check(rs == m_rs, "R5 scl_rise", int'(rs), int'(m_rs));
            check(sm == m_sm, "R4 sample", int'(sm), int'(m_sm));
            check($countones({bs, dc, rs, sm}) <= 1, "R9 strobe overlap", $countones({bs, dc, rs, sm}), 1);
        end
    end

    task automatic wait_start();
        @(negedge clk);
        while (!bs) @(negedge clk);
    endtask

    task automatic measure(input int exp, input string req);
        int n;
        wait_start();
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bs);
        check(n == exp, req, n, exp);
    endtask

    task automatic start_run(input int a, input int b);
        @(negedge clk);
        en = 1'b0; da = 2'(a); db = 6'(b);
        @(negedge clk);
        en = 1'b1;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(scl == 1'b1, "R8 reset scl", int'(scl), 1);
        check({bs, dc, rs, sm} == 4'b0, "R8 reset strobes", int'({bs, dc, rs, sm}), 0);
        rst_n = 1'b1;

        // R1: several divider settings
        start_run(0, 0);
        measure(22, "R1 period A0 B0");
        start_run(1, 2);
        measure(22 * 2 * 3, "R1 period A1 B2");
        start_run(3, 1);
        measure(22 * 4 * 2, "R1 period A3 B1");
        start_run(2, 0);
        measure(22 * 3, "R1 period A2 B0");
        start_run(3, 63);
        measure(22 * 256, "R1 period A3 B63");

        // R6: changing fields while running has no effect
        start_run(0, 1);
        @(negedge clk);
        da = 2'd3; db = 6'd9;
        measure(44, "R6 fields ignored while enabled");
        measure(44, "R6 fields ignored second bit");

        // R6: idle releases the clock and stops the strobes
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            check(scl == 1'b1, "R6 idle scl", int'(scl), 1);
            check({bs, dc, rs, sm} == 4'b0, "R6 idle strobes", int'({bs, dc, rs, sm}), 0);
            @(negedge clk);
        end

        // R7: stretch in the low half lengthens the bit
        start_run(0, 1);
        wait_start();
        stretch = 1'b1;
        n = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            n++;
            check(scl == 1'b0, "R7 stretch holds scl low", int'(scl), 0);
        end
        stretch = 1'b0;
        while (!bs) begin
            @(negedge clk);
            n++;
        end
        check(n == 54, "R7 stretched period", n, 54);

        // R7: stretch in the high half is ignored
        @(negedge clk);
        while (!rs) @(negedge clk);
        stretch = 1'b1;
        n = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            n++;
        end
        stretch = 1'b0;
        while (!bs) begin
            @(negedge clk);
            n++;
        end
        check(n == 22, "R7 high-half stretch ignored", n, 22);

        // R5: restart after a one-cycle idle
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        check(bs == 1'b1, "R5 first bit after enable", int'(bs), 1);
        repeat (30) @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule